// File: doc/BRIEF.md
# CAN FD Transmit Payload Padder

This block feeds the data bytes of one transmit buffer element, one byte at a time, to a CAN FD frame serializer. When a frame starts, the block turns the frame's data length code and its FD flag into a payload byte count. It compares that count with the element data size held in a small configuration register. Bytes the element actually stores are fetched in order from buffer storage over a read port with one cycle of latency. Every requested byte past the stored data is sent as the fixed padding value 0xCC.

The configuration register accepts a write only when the same write also carries both the configuration-change-enable bit and the init bit set. All other writes are dropped. The serializer takes bytes through a valid/ready stream. A single-cycle done pulse tells it that the payload is complete. The element size is captured when a frame starts, so a register write during a frame only affects later frames.

Top module: `canfd_tx_padder`

## Requirements
- R1: After a synchronous reset, `cfg_size` is 0 (8-byte elements), `out_valid` is low and `frm_done` is low.
- R2: A write with `cfg_wr_en`, `cfg_chg_en` and `cfg_init` all high loads `cfg_wr_size` into `cfg_size` on the next cycle.
- R3: A write with either `cfg_chg_en` or `cfg_init` low leaves `cfg_size` unchanged.
- R4: Size codes 0,1,2,3,4,5,6,7 select element data sizes of 8,12,16,20,24,32,48,64 bytes.
- R5: DLC values 0 to 8 request that many bytes. With `frm_fd` high, DLC 9 to 15 request 12,16,20,24,32,48,64 bytes. With `frm_fd` low, any DLC above 8 requests 8 bytes.
- R6: Stored bytes are read at addresses 0 up to min(requested, element size)−1, in ascending order, each exactly once. Each read is issued one cycle before its data is needed, and that data appears on `out_data` two cycles after `rd_en`.
- R7: Byte positions at or beyond the element size are emitted as 0xCC, and no storage read is made for them.
- R8: A byte advances only when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R9: `frm_done` pulses for one cycle, on the cycle after the last payload byte is accepted. No output is valid in that cycle.
- R10: A frame that requests 0 bytes emits nothing and raises `frm_done` on the cycle after `frm_start`.
- R11: The element size is sampled from `cfg_size` at frame start. A write in the same cycle as `frm_start`, or later during the frame, does not change that frame.
- R12: A `frm_start` that arrives while a frame is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_size | input | 3 | Size code to write |
| cfg_chg_en | input | 1 | Configuration-change-enable bit carried with the write |
| cfg_init | input | 1 | Init bit carried with the write |
| cfg_size | output | 3 | Current element size code |
| frm_start | input | 1 | Start a frame (one cycle) |
| frm_dlc | input | 4 | Data length code of the frame |
| frm_fd | input | 1 | Frame is FD format |
| rd_en | output | 1 | Buffer storage read strobe |
| rd_addr | output | 6 | Byte address within the element |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Serializer accepts the byte |
| frm_done | output | 1 | Payload complete pulse |

## Verification
A configuration write and a frame start can hit the same clock edge. The frame must then use the size that was in force before the write, while the register still takes the new code. The bench sets up a small size, issues a permitted write of the largest code together with the start of a 64-byte FD frame, and checks that only 8 stored bytes are read, followed by 56 padding bytes, and that the register reads back the new code afterwards. A second start pulse arrives in the middle of that frame and must not change its length. The main sweep covers every size code, every DLC and both frame formats, under steady, alternating and pseudo-random backpressure.

// File: rtl/canfd_pad_pkg.sv
package canfd_pad_pkg;

  localparam int CODE_W    = 3;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 64;
  localparam int ADDR_W    = $clog2(MAX_BYTES);
  localparam int LEN_W     = ADDR_W + 1;

  typedef logic [LEN_W-1:0] len_t;

  // element data size for a configuration code
  function automatic len_t code_to_size(input logic [CODE_W-1:0] code);
    len_t sz;
    case (code)
      3'd0: sz = len_t'(8);
      3'd1: sz = len_t'(12);
      3'd2: sz = len_t'(16);
      3'd3: sz = len_t'(20);
      3'd4: sz = len_t'(24);
      3'd5: sz = len_t'(32);
      3'd6: sz = len_t'(48);
      default: sz = len_t'(64);
    endcase
    return sz;
  endfunction

  // payload byte count for a data length code
  function automatic len_t dlc_to_len(input logic [DLC_W-1:0] dlc, input logic fd);
    len_t n;
    if (dlc <= 4'd8) n = len_t'(dlc);
    else if (!fd)    n = len_t'(8);
    else begin
      case (dlc)
        4'd9:    n = len_t'(12);
        4'd10:   n = len_t'(16);
        4'd11:   n = len_t'(20);
        4'd12:   n = len_t'(24);
        4'd13:   n = len_t'(32);
        4'd14:   n = len_t'(48);
        default: n = len_t'(64);
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/canfd_pad_cfg.sv
module canfd_pad_cfg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              chg_en,
  input  logic              init,
  output logic [CODE_W-1:0] code_q
);

  logic unlocked;
  assign unlocked = chg_en & init;

  always_ff @(posedge clk) begin
    if (rst)                     code_q <= '0;
    else if (wr_en && unlocked)  code_q <= wr_code;
  end

endmodule

// File: rtl/canfd_pad_seq.sv
module canfd_pad_seq
  import canfd_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DLC_W-1:0]  dlc,
  input  logic              fd,
  input  logic [CODE_W-1:0] code,
  input  logic              slot_free,
  input  logic              accept_last,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fill_valid,
  output logic              fill_pad,
  output logic              fill_last,
  output logic              done
);

  len_t req_len, elem_sz;
  len_t len_q, stored_q, pos_q;
  logic busy_q, issue, take;

  assign req_len = dlc_to_len(dlc, fd);
  assign elem_sz = code_to_size(code);
  assign take    = start && !busy_q;

  // one fetch slot in flight at a time; launched only when the output
  // register will be free to receive it
  assign issue   = busy_q && (pos_q < len_q) && !fill_valid && slot_free;
  assign rd_en   = issue && (pos_q < stored_q);
  assign rd_addr = pos_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      len_q      <= '0;
      stored_q   <= '0;
      pos_q      <= '0;
      fill_valid <= 1'b0;
      fill_pad   <= 1'b0;
      fill_last  <= 1'b0;
      done       <= 1'b0;
    end else begin
      done       <= accept_last || (take && req_len == '0);
      fill_valid <= issue;
      if (issue) begin
        fill_pad  <= (pos_q >= stored_q);
        fill_last <= (pos_q == len_q - len_t'(1));
        pos_q     <= pos_q + len_t'(1);
      end
      if (take) begin
        busy_q   <= (req_len != '0);
        len_q    <= req_len;
        stored_q <= (req_len < elem_sz) ? req_len : elem_sz;
        pos_q    <= '0;
      end else if (accept_last) begin
        busy_q   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/canfd_pad_out.sv
module canfd_pad_out #(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic              fill_pad,
  input  logic              fill_last,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              slot_free,
  output logic              accept_last
);

  logic last_q;

  assign slot_free   = !out_valid || out_ready;
  assign accept_last = out_valid && out_ready && last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      last_q    <= 1'b0;
    end else if (fill_valid) begin
      out_valid <= 1'b1;
      out_data  <= fill_pad ? PAD_BYTE : rd_data;
      last_q    <= fill_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/canfd_tx_padder.sv
module canfd_tx_padder
  import canfd_pad_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CODE_W-1:0] cfg_wr_size,
  input  logic              cfg_chg_en,
  input  logic              cfg_init,
  output logic [CODE_W-1:0] cfg_size,
  input  logic              frm_start,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic              frm_fd,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              frm_done
);

  logic slot_free, accept_last, fill_valid, fill_pad, fill_last;

  canfd_pad_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_code(cfg_wr_size),
    .chg_en(cfg_chg_en), .init(cfg_init), .code_q(cfg_size)
  );

  canfd_pad_seq u_seq (
    .clk(clk), .rst(rst), .start(frm_start), .dlc(frm_dlc), .fd(frm_fd),
    .code(cfg_size), .slot_free(slot_free), .accept_last(accept_last),
    .rd_en(rd_en), .rd_addr(rd_addr), .fill_valid(fill_valid),
    .fill_pad(fill_pad), .fill_last(fill_last), .done(frm_done)
  );

  canfd_pad_out #(.DATA_W(DATA_W), .PAD_BYTE(PAD_BYTE)) u_out (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_pad(fill_pad),
    .fill_last(fill_last), .rd_data(rd_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .slot_free(slot_free),
    .accept_last(accept_last)
  );

endmodule

// File: rtl/canfd_pad_chk.sv
module canfd_pad_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic [2:0]        cfg_wr_size,
  input logic              cfg_chg_en,
  input logic              cfg_init,
  input logic [2:0]        cfg_size,
  input logic              rd_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              frm_done
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cfg_size == 3'd0 && !out_valid && !frm_done));

  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_chg_en && cfg_init) |=> (cfg_size == $past(cfg_wr_size)));

  p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !(cfg_chg_en && cfg_init)) |=> $stable(cfg_size));

  p_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> !out_valid);

endmodule

bind canfd_tx_padder canfd_pad_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_size(cfg_wr_size),
  .cfg_chg_en(cfg_chg_en), .cfg_init(cfg_init), .cfg_size(cfg_size),
  .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .frm_done(frm_done)
);

// File: tb/canfd_tx_padder_test.sv
`timescale 1ns/1ps
module canfd_tx_padder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0, cfg_chg_en = 1'b0, cfg_init = 1'b0;
  logic [2:0] cfg_wr_size = '0;
  logic [2:0] cfg_size;
  logic       frm_start = 1'b0, frm_fd = 1'b0;
  logic [3:0] frm_dlc = '0;
  logic       rd_en;
  logic [5:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic       out_valid, out_ready = 1'b0, frm_done;
  logic [7:0] out_data;

  int checks = 0, failures = 0;
  int tb_code = 0;
  int exp_rd = 0, rd_stored = 0, frame_seed = 0;
  logic [7:0] lfsr = 8'hA5;
  logic       toggle = 1'b0;

  always #4 clk = ~clk;

  canfd_tx_padder uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_size(cfg_wr_size),
    .cfg_chg_en(cfg_chg_en), .cfg_init(cfg_init), .cfg_size(cfg_size),
    .frm_start(frm_start), .frm_dlc(frm_dlc), .frm_fd(frm_fd),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .frm_done(frm_done)
  );

  function automatic int tb_size(input int code);
    int t [8] = '{8, 12, 16, 20, 24, 32, 48, 64};
    return t[code];
  endfunction

  function automatic int tb_len(input int dlc, input int fd);
    int t [7] = '{12, 16, 20, 24, 32, 48, 64};
    if (dlc <= 8) return dlc;
    if (fd == 0) return 8;
    return t[dlc-9];
  endfunction

  function automatic logic [7:0] tb_byte(input int seed, input int pos);
    return 8'((seed * 29 + pos * 11 + 3) & 255);
  endfunction

  // storage model with one cycle of read latency; checks R6 address order
  always @(posedge clk) begin
    if (rd_en) begin
      checks++;
      if (int'(rd_addr) != exp_rd || exp_rd >= rd_stored) begin
        failures++;
        $display("FAIL R6/R7 read address actual=%0d expected=%0d (stored=%0d)",
                 rd_addr, exp_rd, rd_stored);
      end
      exp_rd++;
      rd_data <= tb_byte(frame_seed, int'(rd_addr));
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int code, input bit chg, input bit ini);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_size = 3'(code); cfg_chg_en = chg; cfg_init = ini;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_chg_en = 1'b0; cfg_init = 1'b0;
    if (chg && ini) begin
      check(int'(cfg_size) == code, "R2 write accepted", int'(cfg_size), code);
      tb_code = code;
    end else begin
      check(int'(cfg_size) == tb_code, "R3 write ignored", int'(cfg_size), tb_code);
    end
  endtask

  task automatic run_frame(input int dlc, input int fd, input int seed, input int mode,
                           input bit wr_same, input int wr_code, input bit mid_start);
    int len, stored, idx, cyc;
    bit expect_done, mid_sent;
    len = tb_len(dlc, fd);
    stored = (len < tb_size(tb_code)) ? len : tb_size(tb_code);
    @(negedge clk);
    exp_rd = 0; rd_stored = stored; frame_seed = seed;
    frm_start = 1'b1; frm_dlc = 4'(dlc); frm_fd = 1'(fd);
    if (wr_same) begin
      cfg_wr_en = 1'b1; cfg_wr_size = 3'(wr_code); cfg_chg_en = 1'b1; cfg_init = 1'b1;
    end
    @(negedge clk);
    frm_start = 1'b0; cfg_wr_en = 1'b0; cfg_chg_en = 1'b0; cfg_init = 1'b0;
    if (wr_same) tb_code = wr_code;
    idx = 0; cyc = 0; mid_sent = 1'b0;
    expect_done = (len == 0);
    forever begin
      frm_start = 1'b0;
      if (expect_done) begin
        check(frm_done === 1'b1, (len == 0) ? "R10 done after empty frame" : "R9 done pulse",
              int'(frm_done), 1);
        break;
      end
      if (frm_done) begin
        failures++;
        $display("FAIL R9 early done actual=1 expected=0 at byte %0d of %0d", idx, len);
        break;
      end
      if (mid_start && idx == 3 && !mid_sent) begin
        frm_start = 1'b1; frm_dlc = 4'd1; frm_fd = 1'b0; mid_sent = 1'b1;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      toggle = ~toggle;
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? toggle : lfsr[0];
      if (out_valid && out_ready) begin
        if (idx < stored)
          check(out_data == tb_byte(seed, idx), "R6 stored byte", int'(out_data),
                int'(tb_byte(seed, idx)));
        else
          check(out_data == 8'hCC, "R7 padding byte", int'(out_data), 8'hCC);
        idx++;
        if (idx == len) expect_done = 1'b1;
      end
      cyc++;
      if (cyc > 2000) begin
        failures++;
        $display("FAIL R8 frame stalled actual=%0d expected=%0d bytes", idx, len);
        break;
      end
      @(negedge clk);
    end
    frm_start = 1'b0;
    out_ready = 1'b0;
    @(negedge clk);
    check(frm_done == 1'b0, "R9 single-cycle done", int'(frm_done), 0);
    check(exp_rd == stored, "R6 read count", exp_rd, stored);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_size == 3'd0, "R1 reset size", int'(cfg_size), 0);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(frm_done == 1'b0, "R1 reset done", int'(frm_done), 0);

    // R3: each locked combination drops the write
    cfg_write(5, 1'b1, 1'b0);
    cfg_write(5, 1'b0, 1'b1);
    cfg_write(5, 1'b0, 1'b0);

    // R8: hold under backpressure (ready low for several cycles)
    run_frame(3, 0, 77, 2, 1'b0, 0, 1'b0);

    // R4 R5 R6 R7 R8 R9 R10: full sweep of size code, format and DLC
    for (int code = 0; code < 8; code++) begin
      cfg_write(code, 1'b1, 1'b1);
      for (int fd = 0; fd < 2; fd++)
        for (int dlc = 0; dlc < 16; dlc++)
          run_frame(dlc, fd, code * 32 + fd * 16 + dlc, (code + fd + dlc) % 3,
                    1'b0, 0, 1'b0);
    end

    // R11 R12: write in the start cycle, second start mid-frame
    cfg_write(0, 1'b1, 1'b1);
    run_frame(15, 1, 200, 0, 1'b1, 7, 1'b1);
    check(cfg_size == 3'd7, "R11 register took new code", int'(cfg_size), 7);
    // R11: a write during a frame leaves that frame's size alone
    fork
      run_frame(14, 1, 201, 1, 1'b0, 0, 1'b0);
      begin
        repeat (6) @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_size = 3'd0; cfg_chg_en = 1'b1; cfg_init = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_chg_en = 1'b0; cfg_init = 1'b0;
      end
    join
    tb_code = 0;
    check(cfg_size == 3'd0, "R2 mid-frame write landed", int'(cfg_size), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule